// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block performs the arithmetic instructions of a small register-based
virtual machine of the kind used for in-kernel packet filtering. Each request
gives an 8-bit opcode, the current 64-bit destination register value, the
64-bit source register value and a 32-bit immediate. The unit returns the
64-bit value that should be written back to the destination. The opcode
selects the operand width: a 32-bit class and a 64-bit class. It also selects
whether the second operand is the source register or the immediate, and it
selects one of fourteen operations.

Most operations finish one cycle after they are accepted. Multiply, divide and
modulo go to a bit-serial engine and take one step per operand bit. While that
engine runs, `busy` is high and new requests are refused. A one-cycle `done`
pulse marks every finished result. The surrounding pipeline owns the register
file, instruction fetch and writeback.

Top module: `vm_alu`

## Requirements
- R1: The opcode is split into three fields. Bits [2:0] give the class, and only 3'b100 (32-bit) and 3'b111 (64-bit) are presented. Bit 3 picks the second operand: 0 means the immediate and 1 means the source register. Bits [7:4] give the operation: 0 add, 1 subtract, 2 multiply, 3 unsigned divide, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 two's-complement negate of the destination, 9 unsigned modulo, A xor, B move (result is the second operand), C arithmetic right shift, D byte-order conversion.
- R2: In the 32-bit class both operands are cut to their low 32 bits before the operation. Every result except byte-order conversion is then zero-extended, so result[63:32] is 0.
- R3: An immediate used as the second operand is sign-extended from bit 31 in the 64-bit class. In the 32-bit class it is taken as 32 bits.
- R4: The shift amount is the low 5 bits of the second operand in the 32-bit class and the low 6 bits in the 64-bit class.
- R5: Logical right shift fills with zeros. Arithmetic right shift fills with the sign bit of the operand width (bit 31 or bit 63).
- R6: Divide by zero returns 0. Modulo by zero returns the destination operand unchanged (after the 32-bit cut in that class).
- R7: Byte-order conversion acts on the destination only. Its width is 16 when the immediate is 16, 32 when it is 32, and 64 for any other value. With opcode bit 3 = 1 the low width bytes are reversed. With bit 3 = 0 they are kept in place. Bits above the width are 0, in either class.
- R8: A request is accepted when `start` is high and `busy` is low. Operations other than multiply, divide and modulo raise `done` with the result one clock after acceptance, and `busy` stays low.
- R9: Multiply, divide and modulo raise `busy` in the clock after acceptance. `busy` stays high until the clock in which `done` pulses with the result.
- R10: `start` is ignored while `busy` is high. The running operation's result is unchanged and no extra `done` pulse appears.
- R11: During reset `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when busy is low |
| opcode | input | 8 | Operation, source select and class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 64 | Value to write back to the destination |

## Verification
The assertions assume two things about the inputs. Whenever a request can be accepted, the class field is one of the two arithmetic classes. The operation field never holds the two unused codes. The random stimulus keeps to this: it draws the class only from those two values and the operation only from the fourteen defined codes. The byte-order immediate comes from {16, 32, 64} with occasional other values. Directed cases cover zero divisors, shift counts above the width, negative immediates, sign-filled shifts and requests issued while the serial engine is busy.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc,
        OP_END  = 4'hd
    } alu_op_e;

    typedef enum logic [1:0] {
        SEQ_MUL = 2'd0,
        SEQ_DIV = 2'd1,
        SEQ_MOD = 2'd2
    } seq_kind_e;

    localparam logic [2:0] CLS_NARROW = 3'b100;
    localparam logic [2:0] CLS_WIDE   = 3'b111;

    function automatic logic needs_seq(alu_op_e op);
        return (op == OP_MUL) || (op == OP_DIV) || (op == OP_MOD);
    endfunction

endpackage

// File: rtl/vm_alu_fast.sv
module vm_alu_fast
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e             op,
    input  logic                wide,
    input  logic                to_big,
    input  logic [DATA_W-1:0]   a_op,
    input  logic [DATA_W-1:0]   b_op,
    input  logic [DATA_W-1:0]   dst_full,
    input  logic [DATA_W/2-1:0] imm,
    output logic [DATA_W-1:0]   res
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int NBYTES = DATA_W / 8;

    logic [SH_W-1:0]          shamt;
    logic signed [HALF_W-1:0] lo_signed;
    logic signed [HALF_W-1:0] lo_sra;
    logic [DATA_W-1:0]        rev_all;
    logic [DATA_W-1:0]        swap_res;
    logic [DATA_W-1:0]        raw;
    int unsigned              ew;

    always_comb begin
        shamt     = wide ? b_op[SH_W-1:0] : {1'b0, b_op[SH_W-2:0]};
        lo_signed = a_op[HALF_W-1:0];
        lo_sra    = lo_signed >>> shamt;

        for (int i = 0; i < NBYTES; i++) begin
            rev_all[i*8 +: 8] = dst_full[(NBYTES-1-i)*8 +: 8];
        end
        if (imm == HALF_W'(16))      ew = 16;
        else if (imm == HALF_W'(32)) ew = 32;
        else                         ew = DATA_W;
        if (to_big) begin
            swap_res = rev_all >> (DATA_W - ew);
        end else if (ew == DATA_W) begin
            swap_res = dst_full;
        end else begin
            swap_res = dst_full & ((DATA_W'(1) << ew) - DATA_W'(1));
        end

        unique case (op)
            OP_ADD:  raw = a_op + b_op;
            OP_SUB:  raw = a_op - b_op;
            OP_OR:   raw = a_op | b_op;
            OP_AND:  raw = a_op & b_op;
            OP_XOR:  raw = a_op ^ b_op;
            OP_LSH:  raw = a_op << shamt;
            OP_RSH:  raw = a_op >> shamt;
            OP_NEG:  raw = DATA_W'(0) - a_op;
            OP_MOV:  raw = b_op;
            OP_ARSH: raw = wide ? DATA_W'($signed(a_op) >>> shamt)
                                : {{HALF_W{1'b0}}, lo_sra};
            OP_END:  raw = swap_res;
            default: raw = '0;
        endcase

        if (!wide && op != OP_END) res = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        else                       res = raw;
    end

endmodule

// File: rtl/vm_alu_seq.sv
module vm_alu_seq
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  seq_kind_e         kind,
    input  logic [DATA_W-1:0] a_op,
    input  logic [DATA_W-1:0] b_op,
    output logic              fin,
    output logic [DATA_W-1:0] res
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              run;
        logic              fin;
        logic [CNT_W-1:0]  cnt;
        seq_kind_e         kind;
        logic              divz;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] a0;
        logic [DATA_W-1:0] res;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [DATA_W:0]   trial;
    logic [DATA_W:0]   diff;
    logic              ge;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        trial    = {st_q.acc, st_q.x[DATA_W-1]};
        diff     = trial - {1'b0, st_q.y};
        ge       = trial >= {1'b0, st_q.y};

        if (load) begin
            st_d.run  = 1'b1;
            st_d.cnt  = CNT_W'(DATA_W);
            st_d.kind = kind;
            st_d.divz = (b_op == '0);
            st_d.x    = a_op;
            st_d.y    = b_op;
            st_d.acc  = '0;
            st_d.a0   = a_op;
        end else if (st_q.run) begin
            if (st_q.kind == SEQ_MUL) begin
                if (st_q.y[0]) st_d.acc = st_q.acc + st_q.x;
                st_d.x = st_q.x << 1;
                st_d.y = st_q.y >> 1;
            end else begin
                st_d.x   = {st_q.x[DATA_W-2:0], ge};
                st_d.acc = ge ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
            end
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
                unique case (st_q.kind)
                    SEQ_MUL: st_d.res = st_d.acc;
                    SEQ_DIV: st_d.res = st_q.divz ? '0 : st_d.x;
                    default: st_d.res = st_q.divz ? st_q.a0 : st_d.acc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fin = st_q.fin;
    assign res = st_q.res;

    // R9: the owner never reloads the engine while it is stepping
    a_r9_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !st_q.run);

    // R9: a running engine always has steps left
    a_r9_steps_left: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> st_q.cnt != '0);

endmodule

// File: rtl/vm_alu.sv
module vm_alu
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [31:0]       imm,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              wide;
        logic              is_end;
        logic [DATA_W-1:0] res;
    } top_st_t;

    top_st_t st_d, st_q;

    alu_op_e           op;
    logic              wide;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] pick_b;
    logic [DATA_W-1:0] a_op;
    logic [DATA_W-1:0] b_op;
    logic              accept;
    logic              launch;
    seq_kind_e         kind;
    logic [DATA_W-1:0] fast_res;
    logic              seq_fin;
    logic [DATA_W-1:0] seq_res;

    always_comb begin
        op      = alu_op_e'(opcode[7:4]);
        wide    = (opcode[2:0] == CLS_WIDE);
        imm_ext = wide ? {{(DATA_W-32){imm[31]}}, imm} : {{(DATA_W-32){1'b0}}, imm};
        pick_b  = opcode[3] ? src_val : imm_ext;
        a_op    = wide ? dst_val : {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
        b_op    = wide ? pick_b  : {{HALF_W{1'b0}}, pick_b[HALF_W-1:0]};
        accept  = start && !st_q.busy;
        launch  = accept && needs_seq(op);
        unique case (op)
            OP_MUL:  kind = SEQ_MUL;
            OP_DIV:  kind = SEQ_DIV;
            default: kind = SEQ_MOD;
        endcase
    end

    vm_alu_fast #(.DATA_W(DATA_W)) i_fast (
        .op       (op),
        .wide     (wide),
        .to_big   (opcode[3]),
        .a_op     (a_op),
        .b_op     (b_op),
        .dst_full (dst_val),
        .imm      (imm),
        .res      (fast_res)
    );

    vm_alu_seq #(.DATA_W(DATA_W)) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .kind  (kind),
        .a_op  (a_op),
        .b_op  (b_op),
        .fin   (seq_fin),
        .res   (seq_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.wide   = wide;
            st_d.is_end = (op == OP_END);
            if (needs_seq(op)) begin
                st_d.busy = 1'b1;
            end else begin
                st_d.done = 1'b1;
                st_d.res  = fast_res;
            end
        end else if (st_q.busy && seq_fin) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = st_q.wide ? seq_res : {{HALF_W{1'b0}}, seq_res[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    // R1: input assumption, only the two arithmetic classes are requested
    a_r1_legal_class: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (opcode[2:0] == CLS_NARROW || opcode[2:0] == CLS_WIDE));

    // R2: narrow-class results carry no upper bits
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.wide && !st_q.is_end) |-> result[DATA_W-1:HALF_W] == '0);

    // R8: single-cycle operations answer in the next clock
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !needs_seq(op)) |=> (done && !busy));

    // R9: serial operations raise busy with no early done
    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !done));

    // R9: busy only drops together with the done pulse
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: no done while the engine has not finished
    a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_fin) |=> !done);

endmodule

// File: tb/test_vm_alu.sv
module test_vm_alu;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [W-1:0]  dst_val = '0;
    logic [W-1:0]  src_val = '0;
    logic [31:0]   imm = '0;
    logic          busy;
    logic          done;
    logic [W-1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    vm_alu #(.DATA_W(W)) i_vm_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [7:0] opc, input logic [W-1:0] d,
                                           input logic [W-1:0] s, input logic [31:0] im);
        logic wide;
        logic [W-1:0] a, b, bs, r;
        logic [5:0] sh;
        logic signed [31:0] t32;
        wide = (opc[2:0] == 3'b111);
        bs = opc[3] ? s : (wide ? {{32{im[31]}}, im} : {32'h0, im});
        a  = wide ? d  : {32'h0, d[31:0]};
        b  = wide ? bs : {32'h0, bs[31:0]};
        sh = wide ? b[5:0] : {1'b0, b[4:0]};
        t32 = a[31:0];
        case (opc[7:4])
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: r = (b == 0) ? '0 : a / b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a << sh;
            4'h7: r = a >> sh;
            4'h8: r = -a;
            4'h9: r = (b == 0) ? a : a % b;
            4'ha: r = a ^ b;
            4'hb: r = b;
            4'hc: r = wide ? W'($signed(a) >>> sh) : {32'h0, 32'(t32 >>> sh)};
            default: begin
                if (im == 16)
                    return opc[3] ? {48'h0, d[7:0], d[15:8]} : {48'h0, d[15:0]};
                if (im == 32)
                    return opc[3] ? {32'h0, d[7:0], d[15:8], d[23:16], d[31:24]}
                                  : {32'h0, d[31:0]};
                if (!opc[3]) return d;
                for (int i = 0; i < 8; i++) r[i*8 +: 8] = d[(7-i)*8 +: 8];
                return r;
            end
        endcase
        if (!wide) r = {32'h0, r[31:0]};
        return r;
    endfunction

    // issue one request, wait for done, compare with model and latency rule
    task automatic run_op(input logic [7:0] opc, input logic [W-1:0] d,
                          input logic [W-1:0] s, input logic [31:0] im, input string req);
        int lat;
        logic seq_op;
        logic [W-1:0] exp;
        seq_op = (opc[7:4] == 4'h2) || (opc[7:4] == 4'h3) || (opc[7:4] == 4'h9);
        exp = model(opc, d, s, im);
        @(negedge clk);
        opcode = opc; dst_val = d; src_val = s; imm = im; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (seq_op) check(busy === 1'b1 && done === 1'b0, "R9 busy after launch", W'(busy), W'(1));
        lat = 1;
        while (done !== 1'b1 && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(result === exp, req, result, exp);
        if (!seq_op) check(lat == 1, "R8 latency", W'(lat), W'(1));
        else         check(busy === 1'b0, "R9 busy cleared with done", W'(busy), W'(0));
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] opc;
        logic [31:0] im;
        int dones;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R11 busy in reset", W'(busy), W'(0));
        check(done === 1'b0, "R11 done in reset", W'(done), W'(0));
        check(result === '0, "R11 result in reset", result, '0);
        rst_n = 1'b1;

        // R1 basic operations, register source, wide class
        run_op(8'h0f, 64'h0123_4567_89ab_cdef, 64'h1111_1111_1111_1111, 0, "R1 add");
        run_op(8'h1f, 64'h5, 64'h7, 0, "R1 sub wrap");
        run_op(8'h8f, 64'h1, 64'h0, 0, "R1 negate");
        run_op(8'hbf, 64'h0, 64'hdead_beef_0000_0001, 0, "R1 move");
        run_op(8'h2f, 64'hffff_ffff_ffff_fffd, 64'h3, 0, "R1 multiply");
        // R2 narrow truncation and zero extension
        run_op(8'h0c, 64'hffff_ffff_ffff_ffff, 64'h2, 0, "R2 narrow add");
        run_op(8'h2c, 64'hffff_0000_8000_0000, 64'h2, 0, "R2 narrow multiply");
        // R3 immediate sign extension vs narrow
        run_op(8'h07, 64'h10, 0, 32'hffff_fff0, "R3 wide imm sext");
        run_op(8'hb7, 64'h0, 0, 32'h8000_0000, "R3 wide mov imm");
        run_op(8'hb4, 64'h0, 0, 32'h8000_0000, "R3 narrow mov imm");
        // R4 shift masking
        run_op(8'h64, 64'h1, 0, 32'd33, "R4 narrow shift mask");
        run_op(8'h67, 64'h1, 0, 32'd65, "R4 wide shift mask");
        // R5 logical vs arithmetic right shift
        run_op(8'h7f, 64'h8000_0000_0000_0000, 64'd4, 0, "R5 logical rsh");
        run_op(8'hcf, 64'h8000_0000_0000_0000, 64'd4, 0, "R5 arith rsh wide");
        run_op(8'hc4, 64'h0000_0000_8000_0000, 0, 32'd8, "R5 arith rsh narrow");
        // R6 zero divisor
        run_op(8'h3f, 64'h1234, 64'h0, 0, "R6 div by zero");
        run_op(8'h9f, 64'h1234_5678_9abc, 64'h0, 0, "R6 mod by zero");
        run_op(8'h94, 64'hffff_ffff_0000_0042, 0, 0, "R6 narrow mod by zero");
        run_op(8'h3f, 64'd1000, 64'd7, 0, "R6 div normal");
        // R7 byte order conversion
        run_op(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd16, "R7 big 16");
        run_op(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd32, "R7 big 32");
        run_op(8'hdc, 64'h1122_3344_5566_7788, 0, 32'd64, "R7 big 64");
        run_op(8'hd4, 64'h1122_3344_5566_7788, 0, 32'd16, "R7 little 16");
        run_op(8'hd4, 64'h1122_3344_5566_7788, 0, 32'd64, "R7 little 64");

        // R10 start held while busy is ignored
        @(negedge clk);
        opcode = 8'h2f; dst_val = 64'd123456789; src_val = 64'd1000; imm = 0; start = 1'b1;
        @(negedge clk);
        opcode = 8'h0f; dst_val = 64'd1; src_val = 64'd1;
        repeat (10) @(negedge clk);
        start = 1'b0;
        dones = 0;
        while (done !== 1'b1 && dones < 300) begin
            @(negedge clk);
            dones++;
        end
        check(result === 64'd123456789000, "R10 result unchanged", result, 64'd123456789000);
        dones = 0;
        repeat (5) begin
            @(negedge clk);
            if (done === 1'b1) dones++;
        end
        check(dones == 0, "R10 no extra done", W'(dones), W'(0));

        // random mix across R1..R9
        for (int k = 0; k < 300; k++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 13));
            opc = {o, 1'($urandom), ($urandom_range(0, 1) == 1) ? 3'b111 : 3'b100};
            im = $urandom;
            if (o == 4'hd) im = (k % 7 == 0) ? 32'd8 : 32'(16 << $urandom_range(0, 2));
            if (k % 5 == 0) im = $urandom_range(0, 70);
            run_op(opc, {$urandom, $urandom}, (k % 11 == 0) ? '0 : {$urandom, $urandom},
                   im, "R1 random mix");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule